// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block is the control logic that sits beside the pipeline registers of a five-stage core: fetch, decode, execute, memory and writeback. Each cycle it looks at the source register indices held in decode and at the destinations, write enables and values that the later stages are about to produce. From these it picks the freshest value for every decode operand. It also raises the stall and bubble controls for the pipeline registers, and it selects where fetch takes its next program counter from.

The program counter is general register `PC_REG`, so a branch shows up as a write to that register. An execute-stage write to it flushes the younger instructions. A memory-stage write to it redirects fetch. The writeback stage never writes the program counter into the register file. All outputs are combinational from the current stage contents. The pipeline registers act on the stall and bubble controls at the next clock edge. Clock and reset feed only the embedded checks.

Top module: `pipe_hazard_unit`

## Requirements
- R1: A decode source whose index equals `PC_REG` always receives its register-file value `rf_rdata` lane, whatever the later stages write.
- R2: For any other index, the operand comes from the first enabled producer with a matching destination. The order is: execute ALU result, memory load data, memory ALU result, writeback load data, writeback ALU result.
- R3: When no enabled producer matches a source index, that operand equals its register-file lane.
- R4: When `ex_ld_we` is high and `ex_ld_idx` equals any of the `NUM_SRC` decode indices, `stall_fetch`, `stall_decode` and `bubble_execute` are all 1.
- R5: A PC change is an execute-stage write to `PC_REG`, through either `ex_alu_we`/`ex_alu_idx` or `ex_ld_we`/`ex_ld_idx`. A PC change sets `bubble_execute`. It also sets `bubble_decode`, unless `stall_decode` is 1 in the same cycle.
- R6: With no load-use match and no PC change, all four stall and bubble outputs are 0.
- R7: `pc_redir_sel` is 2 with `pc_redir_val` equal to `mem_ld_val` when the memory stage loads into `PC_REG`. Otherwise it is 1 with `mem_alu_val` when the memory ALU result targets `PC_REG`. Otherwise it is 0 with a value of 0.
- R8: `rf_we_alu` and `rf_we_ld` follow `wb_alu_we` and `wb_ld_we`, but are forced to 0 when their index is `PC_REG`. `rf_we_link` follows `wb_link_we`, which writes the return address to `LINK_REG`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded checks |
| rst_n | input | 1 | Active-low reset for the embedded checks |
| dec_src_idx | input | NUM_SRC*IDX_W | Decode source indices, lane k at bits k*IDX_W |
| rf_rdata | input | NUM_SRC*DATA_W | Register-file read data per lane, lane k at bits k*DATA_W |
| ex_alu_idx | input | IDX_W | Execute ALU destination |
| ex_alu_we | input | 1 | Execute ALU result will be written |
| ex_alu_val | input | DATA_W | Execute ALU result |
| ex_ld_idx | input | IDX_W | Execute load destination |
| ex_ld_we | input | 1 | Execute holds a load that writes a register |
| mem_alu_idx | input | IDX_W | Memory-stage ALU destination |
| mem_alu_we | input | 1 | Memory-stage ALU write enable |
| mem_alu_val | input | DATA_W | Memory-stage ALU result |
| mem_ld_idx | input | IDX_W | Memory-stage load destination |
| mem_ld_we | input | 1 | Memory-stage load write enable |
| mem_ld_val | input | DATA_W | Memory-stage loaded data |
| wb_alu_idx | input | IDX_W | Writeback ALU destination |
| wb_alu_we | input | 1 | Writeback ALU write enable |
| wb_alu_val | input | DATA_W | Writeback ALU result |
| wb_ld_idx | input | IDX_W | Writeback load destination |
| wb_ld_we | input | 1 | Writeback load write enable |
| wb_ld_val | input | DATA_W | Writeback loaded data |
| wb_link_we | input | 1 | Writeback link write request |
| opnd | output | NUM_SRC*DATA_W | Forwarded operands, same lane layout as rf_rdata |
| stall_fetch | output | 1 | Hold the fetch PC |
| stall_decode | output | 1 | Hold the decode register |
| bubble_decode | output | 1 | Load a no-op into the decode register |
| bubble_execute | output | 1 | Load a no-op into the execute register |
| pc_redir_sel | output | 2 | Fetch PC source: 0 none, 1 memory ALU, 2 memory load |
| pc_redir_val | output | DATA_W | Redirect target, 0 when no redirect |
| rf_we_alu | output | 1 | Register-file write enable, ALU port |
| rf_we_ld | output | 1 | Register-file write enable, load port |
| rf_we_link | output | 1 | Register-file write enable, link register |

## Verification
The bench builds the unit with `IDX_W = 3`, `PC_REG = 7`, `LINK_REG = 6`, `DATA_W = 16` and four sources. With only eight register indices, random destinations often collide with decode sources and with the program-counter index. The priority ladder, load-use stalls with PC writes in the same cycle, and the precedence between redirect sources are therefore reached every few cycles, not only in the directed cases. The 16-bit values keep mismatch reports short while still telling the five producers apart.

// File: rtl/hz_pkg.sv
package hz_pkg;

  // producers in forwarding priority order, index 0 is the strongest
  localparam int unsigned NUM_CAND = 5;
  localparam int unsigned CAND_W   = $clog2(NUM_CAND + 1);
  localparam logic [CAND_W-1:0] CAND_EX_ALU  = CAND_W'(0);
  localparam logic [CAND_W-1:0] CAND_MEM_LD  = CAND_W'(1);
  localparam logic [CAND_W-1:0] CAND_MEM_ALU = CAND_W'(2);
  localparam logic [CAND_W-1:0] CAND_WB_LD   = CAND_W'(3);
  localparam logic [CAND_W-1:0] CAND_WB_ALU  = CAND_W'(4);
  localparam logic [CAND_W-1:0] CAND_NONE    = CAND_W'(NUM_CAND);

  // fetch redirect select encoding
  localparam logic [1:0] REDIR_NONE = 2'd0;
  localparam logic [1:0] REDIR_ALU  = 2'd1;
  localparam logic [1:0] REDIR_LOAD = 2'd2;

  // lowest set bit wins; CAND_NONE when nothing hits
  function automatic logic [CAND_W-1:0] first_hit(input logic [NUM_CAND-1:0] hits);
    logic [CAND_W-1:0] sel;
    sel = CAND_NONE;
    for (int i = NUM_CAND - 1; i >= 0; i--) begin
      if (hits[i]) sel = CAND_W'(i);
    end
    return sel;
  endfunction

endpackage

// File: rtl/hz_fwd_lane.sv
module hz_fwd_lane
  import hz_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned PC_REG = 31
) (
  input  logic [IDX_W-1:0]    src_idx,
  input  logic [IDX_W-1:0]    cand_idx [NUM_CAND],
  input  logic [NUM_CAND-1:0] cand_we,
  input  logic [DATA_W-1:0]   cand_val [NUM_CAND],
  input  logic [DATA_W-1:0]   rf_val,
  output logic [DATA_W-1:0]   opnd,
  output logic [CAND_W-1:0]   src_sel
);

  localparam logic [IDX_W-1:0] PC_IDX = IDX_W'(PC_REG);

  logic [NUM_CAND-1:0] hit;
  logic                reads_pc;

  for (genvar c = 0; c < NUM_CAND; c++) begin : g_cmp
    assign hit[c] = cand_we[c] && (cand_idx[c] == src_idx);
  end

  assign reads_pc = (src_idx == PC_IDX);
  assign src_sel  = reads_pc ? CAND_NONE : first_hit(hit);

  always_comb begin
    if (src_sel == CAND_NONE) opnd = rf_val;
    else                      opnd = cand_val[src_sel];
  end

endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl #(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned PC_REG  = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] dec_idx [NUM_SRC],
  input  logic [IDX_W-1:0] ex_alu_idx,
  input  logic             ex_alu_we,
  input  logic [IDX_W-1:0] ex_ld_idx,
  input  logic             ex_ld_we,
  output logic             load_use,
  output logic             pc_change,
  output logic             stall_fetch,
  output logic             stall_decode,
  output logic             bubble_decode,
  output logic             bubble_execute
);

  localparam logic [IDX_W-1:0] PC_IDX = IDX_W'(PC_REG);

  logic [NUM_SRC-1:0] src_hit;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_lu
    assign src_hit[s] = ex_ld_we && (ex_ld_idx == dec_idx[s]);
  end

  assign load_use  = |src_hit;
  assign pc_change = (ex_alu_we && ex_alu_idx == PC_IDX) ||
                     (ex_ld_we  && ex_ld_idx  == PC_IDX);

  assign stall_fetch    = load_use;
  assign stall_decode   = load_use;
  assign bubble_decode  = pc_change && !stall_decode;
  assign bubble_execute = pc_change || load_use;

  AST_STALL_EMPTIES_EX: assert property (@(posedge clk) disable iff (!rst_n)
    stall_decode |-> bubble_execute);                                   // R4
  AST_HELD_NOT_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall_decode && bubble_decode));                                  // R5
  AST_ALU_PC_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_alu_we && ex_alu_idx == PC_IDX) |-> bubble_execute);            // R5
  AST_QUIET_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_use && !pc_change) |-> !(stall_fetch || bubble_decode || bubble_execute)); // R6

endmodule

// File: rtl/hz_redirect_wb.sv
module hz_redirect_wb
  import hz_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned PC_REG = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  mem_alu_idx,
  input  logic              mem_alu_we,
  input  logic [DATA_W-1:0] mem_alu_val,
  input  logic [IDX_W-1:0]  mem_ld_idx,
  input  logic              mem_ld_we,
  input  logic [DATA_W-1:0] mem_ld_val,
  input  logic [IDX_W-1:0]  wb_alu_idx,
  input  logic              wb_alu_we,
  input  logic [IDX_W-1:0]  wb_ld_idx,
  input  logic              wb_ld_we,
  input  logic              wb_link_we,
  output logic [1:0]        pc_redir_sel,
  output logic [DATA_W-1:0] pc_redir_val,
  output logic              rf_we_alu,
  output logic              rf_we_ld,
  output logic              rf_we_link
);

  localparam logic [IDX_W-1:0] PC_IDX = IDX_W'(PC_REG);

  logic mem_ld_to_pc;
  logic mem_alu_to_pc;

  assign mem_ld_to_pc  = mem_ld_we  && (mem_ld_idx  == PC_IDX);
  assign mem_alu_to_pc = mem_alu_we && (mem_alu_idx == PC_IDX);

  always_comb begin
    if (mem_ld_to_pc) begin
      pc_redir_sel = REDIR_LOAD;
      pc_redir_val = mem_ld_val;
    end else if (mem_alu_to_pc) begin
      pc_redir_sel = REDIR_ALU;
      pc_redir_val = mem_alu_val;
    end else begin
      pc_redir_sel = REDIR_NONE;
      pc_redir_val = '0;
    end
  end

  assign rf_we_alu  = wb_alu_we && (wb_alu_idx != PC_IDX);
  assign rf_we_ld   = wb_ld_we  && (wb_ld_idx  != PC_IDX);
  assign rf_we_link = wb_link_we;

  AST_LOAD_REDIR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ld_we && mem_ld_idx == PC_IDX) |-> (pc_redir_sel == REDIR_LOAD && pc_redir_val == mem_ld_val)); // R7
  AST_IDLE_REDIR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_redir_sel == REDIR_NONE) |-> (pc_redir_val == '0));             // R7
  AST_WB_ALU_SKIPS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_alu |-> (wb_alu_we && wb_alu_idx != PC_IDX));                 // R8
  AST_WB_LD_SKIPS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_ld |-> (wb_ld_we && wb_ld_idx != PC_IDX));                    // R8

endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
  import hz_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned NUM_SRC  = 4,
  parameter int unsigned PC_REG   = 31,
  parameter int unsigned LINK_REG = 30
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC*IDX_W-1:0]  dec_src_idx,
  input  logic [NUM_SRC*DATA_W-1:0] rf_rdata,
  input  logic [IDX_W-1:0]          ex_alu_idx,
  input  logic                      ex_alu_we,
  input  logic [DATA_W-1:0]         ex_alu_val,
  input  logic [IDX_W-1:0]          ex_ld_idx,
  input  logic                      ex_ld_we,
  input  logic [IDX_W-1:0]          mem_alu_idx,
  input  logic                      mem_alu_we,
  input  logic [DATA_W-1:0]         mem_alu_val,
  input  logic [IDX_W-1:0]          mem_ld_idx,
  input  logic                      mem_ld_we,
  input  logic [DATA_W-1:0]         mem_ld_val,
  input  logic [IDX_W-1:0]          wb_alu_idx,
  input  logic                      wb_alu_we,
  input  logic [DATA_W-1:0]         wb_alu_val,
  input  logic [IDX_W-1:0]          wb_ld_idx,
  input  logic                      wb_ld_we,
  input  logic [DATA_W-1:0]         wb_ld_val,
  input  logic                      wb_link_we,
  output logic [NUM_SRC*DATA_W-1:0] opnd,
  output logic                      stall_fetch,
  output logic                      stall_decode,
  output logic                      bubble_decode,
  output logic                      bubble_execute,
  output logic [1:0]                pc_redir_sel,
  output logic [DATA_W-1:0]         pc_redir_val,
  output logic                      rf_we_alu,
  output logic                      rf_we_ld,
  output logic                      rf_we_link
);

  localparam logic [IDX_W-1:0] PC_IDX = IDX_W'(PC_REG);

  // the link index is fixed by the register file; kept here for range sanity
  initial begin
    if (LINK_REG >= (1 << IDX_W) || PC_REG >= (1 << IDX_W) || LINK_REG == PC_REG)
      $error("pipe_hazard_unit: bad register index parameters");
  end

  logic [IDX_W-1:0]    dec_idx  [NUM_SRC];
  logic [IDX_W-1:0]    cand_idx [NUM_CAND];
  logic [NUM_CAND-1:0] cand_we;
  logic [DATA_W-1:0]   cand_val [NUM_CAND];
  logic [CAND_W-1:0]   lane_sel [NUM_SRC];
  logic                load_use;
  logic                pc_change;

  // producers laid out in priority order
  assign cand_idx[CAND_EX_ALU]  = ex_alu_idx;
  assign cand_idx[CAND_MEM_LD]  = mem_ld_idx;
  assign cand_idx[CAND_MEM_ALU] = mem_alu_idx;
  assign cand_idx[CAND_WB_LD]   = wb_ld_idx;
  assign cand_idx[CAND_WB_ALU]  = wb_alu_idx;
  assign cand_we  = {wb_alu_we, wb_ld_we, mem_alu_we, mem_ld_we, ex_alu_we};
  assign cand_val[CAND_EX_ALU]  = ex_alu_val;
  assign cand_val[CAND_MEM_LD]  = mem_ld_val;
  assign cand_val[CAND_MEM_ALU] = mem_alu_val;
  assign cand_val[CAND_WB_LD]   = wb_ld_val;
  assign cand_val[CAND_WB_ALU]  = wb_alu_val;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_lane
    assign dec_idx[k] = dec_src_idx[k*IDX_W +: IDX_W];

    hz_fwd_lane #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W),
      .PC_REG (PC_REG)
    ) u_lane (
      .src_idx  (dec_idx[k]),
      .cand_idx (cand_idx),
      .cand_we  (cand_we),
      .cand_val (cand_val),
      .rf_val   (rf_rdata[k*DATA_W +: DATA_W]),
      .opnd     (opnd[k*DATA_W +: DATA_W]),
      .src_sel  (lane_sel[k])
    );

    AST_PC_READ_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_src_idx[k*IDX_W +: IDX_W] == PC_IDX) |->
        (opnd[k*DATA_W +: DATA_W] == rf_rdata[k*DATA_W +: DATA_W]));    // R1
    AST_EX_RESULT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_src_idx[k*IDX_W +: IDX_W] != PC_IDX && ex_alu_we &&
       ex_alu_idx == dec_src_idx[k*IDX_W +: IDX_W]) |->
        (opnd[k*DATA_W +: DATA_W] == ex_alu_val));                      // R2
    AST_UNMATCHED_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_sel[k] == CAND_NONE) |->
        (opnd[k*DATA_W +: DATA_W] == rf_rdata[k*DATA_W +: DATA_W]));    // R3
  end

  hz_ctrl #(
    .NUM_SRC (NUM_SRC),
    .IDX_W   (IDX_W),
    .PC_REG  (PC_REG)
  ) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .dec_idx        (dec_idx),
    .ex_alu_idx     (ex_alu_idx),
    .ex_alu_we      (ex_alu_we),
    .ex_ld_idx      (ex_ld_idx),
    .ex_ld_we       (ex_ld_we),
    .load_use       (load_use),
    .pc_change      (pc_change),
    .stall_fetch    (stall_fetch),
    .stall_decode   (stall_decode),
    .bubble_decode  (bubble_decode),
    .bubble_execute (bubble_execute)
  );

  hz_redirect_wb #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .PC_REG (PC_REG)
  ) u_redir (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_alu_idx  (mem_alu_idx),
    .mem_alu_we   (mem_alu_we),
    .mem_alu_val  (mem_alu_val),
    .mem_ld_idx   (mem_ld_idx),
    .mem_ld_we    (mem_ld_we),
    .mem_ld_val   (mem_ld_val),
    .wb_alu_idx   (wb_alu_idx),
    .wb_alu_we    (wb_alu_we),
    .wb_ld_idx    (wb_ld_idx),
    .wb_ld_we     (wb_ld_we),
    .wb_link_we   (wb_link_we),
    .pc_redir_sel (pc_redir_sel),
    .pc_redir_val (pc_redir_val),
    .rf_we_alu    (rf_we_alu),
    .rf_we_ld     (rf_we_ld),
    .rf_we_link   (rf_we_link)
  );

  AST_PC_CHANGE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    pc_change |-> (bubble_execute && (bubble_decode != stall_decode))); // R5
  AST_LOAD_USE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    load_use |-> (stall_fetch && stall_decode));                        // R4

endmodule

// File: tb/pipe_hazard_unit_test.sv
module pipe_hazard_unit_test;

  localparam int DW  = 16;
  localparam int IW  = 3;
  localparam int NS  = 4;
  localparam int PCR = 7;
  localparam int LNK = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic [IW-1:0] d_idx [NS];
  logic [DW-1:0] d_rf  [NS];
  logic [NS*IW-1:0] dec_src_idx;
  logic [NS*DW-1:0] rf_rdata;
  logic [IW-1:0] exa_idx, exl_idx, mma_idx, mml_idx, wba_idx, wbl_idx;
  logic          exa_we, exl_we, mma_we, mml_we, wba_we, wbl_we, wb_link;
  logic [DW-1:0] exa_val, mma_val, mml_val, wba_val, wbl_val;

  logic [NS*DW-1:0] opnd;
  logic stall_fetch, stall_decode, bubble_decode, bubble_execute;
  logic [1:0] pc_redir_sel;
  logic [DW-1:0] pc_redir_val;
  logic rf_we_alu, rf_we_ld, rf_we_link;

  always_comb begin
    for (int k = 0; k < NS; k++) begin
      dec_src_idx[k*IW +: IW] = d_idx[k];
      rf_rdata[k*DW +: DW]    = d_rf[k];
    end
  end

  pipe_hazard_unit #(
    .DATA_W (DW), .IDX_W (IW), .NUM_SRC (NS), .PC_REG (PCR), .LINK_REG (LNK)
  ) uut (
    .clk (clk), .rst_n (rst_n),
    .dec_src_idx (dec_src_idx), .rf_rdata (rf_rdata),
    .ex_alu_idx (exa_idx), .ex_alu_we (exa_we), .ex_alu_val (exa_val),
    .ex_ld_idx (exl_idx), .ex_ld_we (exl_we),
    .mem_alu_idx (mma_idx), .mem_alu_we (mma_we), .mem_alu_val (mma_val),
    .mem_ld_idx (mml_idx), .mem_ld_we (mml_we), .mem_ld_val (mml_val),
    .wb_alu_idx (wba_idx), .wb_alu_we (wba_we), .wb_alu_val (wba_val),
    .wb_ld_idx (wbl_idx), .wb_ld_we (wbl_we), .wb_ld_val (wbl_val),
    .wb_link_we (wb_link),
    .opnd (opnd),
    .stall_fetch (stall_fetch), .stall_decode (stall_decode),
    .bubble_decode (bubble_decode), .bubble_execute (bubble_execute),
    .pc_redir_sel (pc_redir_sel), .pc_redir_val (pc_redir_val),
    .rf_we_alu (rf_we_alu), .rf_we_ld (rf_we_ld), .rf_we_link (rf_we_link)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic logic [DW-1:0] ref_opnd(int k);
    int idx = int'(d_idx[k]);
    if (idx == PCR) return d_rf[k];
    if (exa_we && int'(exa_idx) == idx) return exa_val;
    if (mml_we && int'(mml_idx) == idx) return mml_val;
    if (mma_we && int'(mma_idx) == idx) return mma_val;
    if (wbl_we && int'(wbl_idx) == idx) return wbl_val;
    if (wba_we && int'(wba_idx) == idx) return wba_val;
    return d_rf[k];
  endfunction

  function automatic bit ref_load_use();
    bit hit = 0;
    foreach (d_idx[k]) if (exl_we && exl_idx == d_idx[k]) hit = 1;
    return hit;
  endfunction

  function automatic bit ref_pc_change();
    return (exa_we && int'(exa_idx) == PCR) || (exl_we && int'(exl_idx) == PCR);
  endfunction

  task automatic compare_all(string ctx);
    bit lu = ref_load_use();
    bit pcc = ref_pc_change();
    logic [1:0] esel;
    logic [DW-1:0] eval;
    for (int k = 0; k < NS; k++)
      check((int'(d_idx[k]) == PCR) ? "R1" : "R2", $sformatf("%s opnd%0d", ctx, k),
            32'(opnd[k*DW +: DW]), 32'(ref_opnd(k)));
    check("R4", {ctx, " stalls"}, {30'd0, stall_fetch, stall_decode}, {30'd0, lu, lu});
    check("R5", {ctx, " bubbles"}, {30'd0, bubble_decode, bubble_execute},
          {30'd0, pcc && !lu, pcc || lu});
    if (mml_we && int'(mml_idx) == PCR)      begin esel = 2'd2; eval = mml_val; end
    else if (mma_we && int'(mma_idx) == PCR) begin esel = 2'd1; eval = mma_val; end
    else                                     begin esel = 2'd0; eval = '0; end
    check("R7", {ctx, " redir_sel"}, 32'(pc_redir_sel), 32'(esel));
    check("R7", {ctx, " redir_val"}, 32'(pc_redir_val), 32'(eval));
    check("R8", {ctx, " rf_we"}, {29'd0, rf_we_alu, rf_we_ld, rf_we_link},
          {29'd0, wba_we && int'(wba_idx) != PCR, wbl_we && int'(wbl_idx) != PCR, wb_link});
  endtask

  task automatic clear_inputs();
    foreach (d_idx[k]) begin d_idx[k] = '0; d_rf[k] = '0; end
    exa_idx = '0; exl_idx = '0; mma_idx = '0; mml_idx = '0; wba_idx = '0; wbl_idx = '0;
    exa_we = 0; exl_we = 0; mma_we = 0; mml_we = 0; wba_we = 0; wbl_we = 0; wb_link = 0;
    exa_val = '0; mma_val = '0; mml_val = '0; wba_val = '0; wbl_val = '0;
  endtask

  task automatic random_inputs();
    foreach (d_idx[k]) begin d_idx[k] = IW'($urandom); d_rf[k] = DW'($urandom); end
    exa_idx = IW'($urandom); exl_idx = IW'($urandom); mma_idx = IW'($urandom);
    mml_idx = IW'($urandom); wba_idx = IW'($urandom); wbl_idx = IW'($urandom);
    exa_we = 1'($urandom); exl_we = ($urandom % 4) == 0; mma_we = 1'($urandom);
    mml_we = 1'($urandom); wba_we = 1'($urandom); wbl_we = 1'($urandom);
    wb_link = 1'($urandom);
    exa_val = DW'($urandom); mma_val = DW'($urandom); mml_val = DW'($urandom);
    wba_val = DW'($urandom); wbl_val = DW'($urandom);
  endtask

  initial begin
    clear_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: idle inputs give a quiet pipe (R6)
    check("R6", "reset controls", {28'd0, stall_fetch, stall_decode, bubble_decode, bubble_execute}, 32'd0);
    check("R7", "reset redir", {14'd0, pc_redir_sel, pc_redir_val}, 32'd0);
    rst_n = 1'b1;

    // R3: distinct sources, nothing writes them
    @(negedge clk);
    for (int k = 0; k < NS; k++) begin d_idx[k] = IW'(k + 1); d_rf[k] = DW'(16'h1100 + k); end
    exa_we = 1; exa_idx = 3'd6; exa_val = 16'hdead;
    #5;
    for (int k = 0; k < NS; k++)
      check("R3", $sformatf("unmatched opnd%0d", k), 32'(opnd[k*DW +: DW]), 32'(16'h1100 + k));
    check("R6", "no hazard controls", {28'd0, stall_fetch, stall_decode, bubble_decode, bubble_execute}, 32'd0);
    compare_all("r3_case");

    // R2: climb the priority ladder on source 0 (index 2)
    @(negedge clk); clear_inputs(); d_idx[0] = 3'd2; d_rf[0] = 16'h0f0f;
    wba_we = 1; wba_idx = 3'd2; wba_val = 16'ha005;
    #5 check("R2", "wb alu", 32'(opnd[DW-1:0]), 32'h0000a005);
    @(negedge clk); wbl_we = 1; wbl_idx = 3'd2; wbl_val = 16'ha004;
    #5 check("R2", "wb load", 32'(opnd[DW-1:0]), 32'h0000a004);
    @(negedge clk); mma_we = 1; mma_idx = 3'd2; mma_val = 16'ha003;
    #5 check("R2", "mem alu", 32'(opnd[DW-1:0]), 32'h0000a003);
    @(negedge clk); mml_we = 1; mml_idx = 3'd2; mml_val = 16'ha002;
    #5 check("R2", "mem load", 32'(opnd[DW-1:0]), 32'h0000a002);
    @(negedge clk); exa_we = 1; exa_idx = 3'd2; exa_val = 16'ha001;
    #5 check("R2", "ex alu", 32'(opnd[DW-1:0]), 32'h0000a001);
    compare_all("r2_ladder");

    // R1: every producer targets the PC index, source 1 reads it
    @(negedge clk); clear_inputs(); d_idx[1] = 3'd7; d_rf[1] = 16'h7777;
    exa_we = 1; exa_idx = 3'd7; exa_val = 16'h1;
    mml_we = 1; mml_idx = 3'd7; mml_val = 16'h2;
    mma_we = 1; mma_idx = 3'd7; mma_val = 16'h3;
    wbl_we = 1; wbl_idx = 3'd7; wbl_val = 16'h4;
    wba_we = 1; wba_idx = 3'd7; wba_val = 16'h5;
    #5 check("R1", "pc read raw", 32'(opnd[2*DW-1:DW]), 32'h00007777);
    check("R5", "alu pc flush", {30'd0, bubble_decode, bubble_execute}, 32'd3);
    compare_all("r1_case");

    // R4: load into index 4, read by source 3 only
    @(negedge clk); clear_inputs();
    for (int k = 0; k < NS; k++) d_idx[k] = IW'(k);
    d_idx[3] = 3'd4; exl_we = 1; exl_idx = 3'd4;
    #5 check("R4", "load-use", {29'd0, stall_fetch, stall_decode, bubble_execute}, 32'd7);
    check("R4", "load-use no dec bubble", 32'(bubble_decode), 32'd0);
    compare_all("r4_case");

    // R5 corner: load into PC while decode reads PC -> stall wins over decode bubble
    @(negedge clk); clear_inputs(); d_idx[2] = 3'd7; exl_we = 1; exl_idx = 3'd7;
    #5 check("R5", "stall+pc change", {28'd0, stall_fetch, stall_decode, bubble_decode, bubble_execute}, 32'hd);
    // R5: load into PC with no reader -> both bubbles
    @(negedge clk); d_idx[2] = 3'd1;
    #5 check("R5", "load pc flush", {28'd0, stall_fetch, stall_decode, bubble_decode, bubble_execute}, 32'h3);

    // R7: both memory producers hit PC, then only ALU, then none
    @(negedge clk); clear_inputs();
    mma_we = 1; mma_idx = 3'd7; mma_val = 16'h4400;
    mml_we = 1; mml_idx = 3'd7; mml_val = 16'h8800;
    #5 check("R7", "load redirect", {14'd0, pc_redir_sel, pc_redir_val}, {14'd0, 2'd2, 16'h8800});
    @(negedge clk); mml_we = 0;
    #5 check("R7", "alu redirect", {14'd0, pc_redir_sel, pc_redir_val}, {14'd0, 2'd1, 16'h4400});
    @(negedge clk); mma_idx = 3'd5;
    #5 check("R7", "no redirect", {14'd0, pc_redir_sel, pc_redir_val}, 32'd0);

    // R8: ALU write to PC suppressed, load write kept, link kept
    @(negedge clk); clear_inputs();
    wba_we = 1; wba_idx = 3'd7; wbl_we = 1; wbl_idx = 3'd3; wb_link = 1;
    #5 check("R8", "wb enables", {29'd0, rf_we_alu, rf_we_ld, rf_we_link}, 32'd3);
    @(negedge clk); wba_idx = 3'd0; wbl_idx = 3'd7; wb_link = 0;
    #5 check("R8", "wb enables swapped", {29'd0, rf_we_alu, rf_we_ld, rf_we_link}, 32'd4);

    // random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      random_inputs();
      #5 compare_all("random");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule